// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps account of the frames a MAC writes into a receive data FIFO and gives the host a 16-bit status word for the oldest finished frame. The MAC side sends four kinds of event: a frame start, one strobe per payload byte, a frame end, and a 4-bit error code that is sampled with the frame end. Each finished frame becomes a descriptor in a queue of up to eight entries. A descriptor holds an error-type code and a byte count.

The host reads the status word at any time. It issues a discard command to drop the oldest descriptor. It also sends one read strobe for each payload byte it takes out of the FIFO. The block uses these strobes to detect a read past the end of the data received so far.

Two kinds of flag are produced. A status-overrun flag stops the block from accepting new frames while the queue is full. A sticky underrun flag drives an adapter-failure output. A receive reset input clears all state, and so does the global reset.

Top module: `rx_status_queue`

## Requirements
- R1: After reset, or while the queue is empty and no frame is arriving, the status word is 0x8000 and `receiving`, `status_ovr`, `rx_underrun` and `adapter_fail` are all low.
- R2: When the queue is not empty, the status word shows the oldest frame. Bit 15 is 0, bits 14..11 hold its error-type code and bits 10..0 hold its byte count. The byte count is the number of `byte_valid` strobes seen after the frame start, including a strobe in the same cycle as the frame end.
- R3: While a frame is arriving and the queue is empty, the status word has bit 15 set, bits 14..11 at zero, and the running byte count in bits 10..0, updated on every strobe.
- R4: The error code sampled with the frame end is stored unchanged when it is one of 4'b1000 (overrun), 4'b1011 (runt), 4'b1100 (alignment), 4'b1101 (CRC), 4'b1001 (oversize) or 4'b0010 (dribble). Any other code is stored as 4'b0000.
- R5: A frame longer than 1514 bytes is stored with code 4'b1001, unless its stored code already has bit 3 set. The byte count saturates at 2047.
- R6: Descriptors leave the queue in the order their frames ended, and the queue holds up to eight of them.
- R7: `status_ovr` is high exactly while eight descriptors are held. A frame start during that time is ignored, together with its bytes and its end. The flag falls in the cycle after a discard.
- R8: `discard` removes the oldest descriptor. When the queue is empty, `discard` has no effect.
- R9: `receiving` rises in the cycle after an accepted frame start and falls in the cycle after the frame end.
- R10: A host read strobe sets `rx_underrun` if the number of bytes already read from the oldest frame is at least that frame's byte count. When the queue is empty, the limit is the running count of the frame in progress. `rx_underrun` drives `adapter_fail` and stays set through discards and new frames.
- R11: `rx_reset` clears the queue, the frame in progress, the read count and `rx_underrun` in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset, asynchronous |
| rx_reset | input | 1 | Synchronous receive reset |
| pkt_start | input | 1 | MAC: a frame begins |
| byte_valid | input | 1 | MAC: one payload byte written |
| pkt_end | input | 1 | MAC: the frame ends |
| err_code | input | 4 | MAC: error type, sampled with `pkt_end` |
| host_rd | input | 1 | Host: one payload byte read |
| discard | input | 1 | Host: drop the oldest descriptor |
| status_word | output | 16 | Incomplete flag, error code, byte count |
| receiving | output | 1 | A frame is being written |
| status_ovr | output | 1 | Queue full, frames refused |
| rx_underrun | output | 1 | Host read past the received data (sticky) |
| adapter_fail | output | 1 | Failure indication raised by underrun |

## Verification
A corrupted read or write pointer shows up on the first status read after the next discard: the host sees a descriptor out of order, or a stale one. A wrong occupancy count shows up sooner. Either `status_ovr` rises at the wrong depth, a ninth frame is accepted, or bit 15 reports empty while descriptors remain. An error in the byte counter or in code normalisation appears in the very next completed descriptor. An error in the read counter sets the underrun flag one read early or one read late, and that flag then stays wrong until a receive reset.

// File: rtl/rx_status_queue.sv
module rx_status_queue #(
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 11,
  parameter int MAX_LEN = 1514
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_reset,
  input  logic             pkt_start,
  input  logic             byte_valid,
  input  logic             pkt_end,
  input  logic [3:0]       err_code,
  input  logic             host_rd,
  input  logic             discard,
  output logic [CNT_W+4:0] status_word,
  output logic             receiving,
  output logic             status_ovr,
  output logic             rx_underrun,
  output logic             adapter_fail
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int QW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_LEN);

  logic [CNT_W+3:0] q [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [QW-1:0]    qc;
  logic [CNT_W-1:0] cur, rdc;

  wire full     = (qc == QW'(DEPTH));
  wire empty    = (qc == '0);
  wire start_ok = pkt_start && !full;
  wire push     = receiving && pkt_end;
  wire pop      = discard && !empty;

  wire [CNT_W-1:0] cnt_nx = (receiving && byte_valid && cur != SAT) ? cur + 1'b1 : cur;

  function automatic logic [3:0] norm(input logic [3:0] c);
    case (c)
      4'b1000, 4'b1011, 4'b1100, 4'b1101, 4'b1001, 4'b0010: norm = c;
      default: norm = 4'b0000;
    endcase
  endfunction

  wire [3:0] code_n   = norm(err_code);
  wire [3:0] code_fin = (cnt_nx > LIM && !code_n[3]) ? 4'b1001 : code_n;

  wire [CNT_W-1:0] top_cnt = q[rp][CNT_W-1:0];
  wire [CNT_W-1:0] limit   = empty ? cur : top_cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; qc <= '0;
      cur <= '0; rdc <= '0;
      receiving <= 1'b0; rx_underrun <= 1'b0;
    end else if (rx_reset) begin
      wp <= '0; rp <= '0; qc <= '0;
      cur <= '0; rdc <= '0;
      receiving <= 1'b0; rx_underrun <= 1'b0;
    end else begin
      if (start_ok) begin
        receiving <= 1'b1;
        cur <= '0;
      end else if (push) begin
        receiving <= 1'b0;
        cur <= '0;
      end else begin
        cur <= cnt_nx;
      end
      if (push) wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      if (push && !pop) qc <= qc + 1'b1;
      else if (pop && !push) qc <= qc - 1'b1;
      if (pop) rdc <= '0;
      else if (host_rd && rdc < limit) rdc <= rdc + 1'b1;
      if (host_rd && !pop && rdc >= limit) rx_underrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !start_ok && !rx_reset) q[wp] <= {code_fin, cnt_nx};
  end

  assign status_word  = empty ? {1'b1, 4'b0000, cur} : {1'b0, q[rp]};
  assign status_ovr   = full;
  assign adapter_fail = rx_underrun;
endmodule

module rx_status_queue_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_reset,
  input logic        pkt_start,
  input logic        discard,
  input logic [15:0] status_word,
  input logic        receiving,
  input logic        status_ovr,
  input logic        rx_underrun
);
  AST_IDLE_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15] && !receiving |-> status_word[10:0] == 11'd0); // R1
  AST_RUNNING_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15] |-> status_word[14:11] == 4'b0000); // R3
  AST_OVERSIZE_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[15] && status_word[10:0] > 11'd1514 |-> status_word[14]); // R5
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    status_ovr && pkt_start && !rx_reset |=> !receiving); // R7
  AST_EMPTY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[15] && discard && !receiving && !rx_reset |=> status_word[15]); // R8
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun && !rx_reset |=> rx_underrun); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> !rx_underrun && !receiving && status_word == 16'h8000); // R11
endmodule

bind rx_status_queue rx_status_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .pkt_start(pkt_start),
  .discard(discard), .status_word(status_word), .receiving(receiving),
  .status_ovr(status_ovr), .rx_underrun(rx_underrun)
);

// File: tb/rx_status_queue_bench.sv
module rx_status_queue_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_reset = 0, pkt_start = 0, byte_valid = 0, pkt_end = 0, host_rd = 0, discard = 0;
  logic [3:0] err_code = 0;
  logic [15:0] status_word;
  logic receiving, status_ovr, rx_underrun, adapter_fail;

  always #10 clk = ~clk;

  rx_status_queue u_rx_status_queue (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .pkt_start(pkt_start),
    .byte_valid(byte_valid), .pkt_end(pkt_end), .err_code(err_code),
    .host_rd(host_rd), .discard(discard), .status_word(status_word),
    .receiving(receiving), .status_ovr(status_ovr), .rx_underrun(rx_underrun),
    .adapter_fail(adapter_fail));

  int n_chk = 0, n_fail = 0;
  logic [15:0] mq[$];
  int rdc = 0;
  bit und = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(logic [3:0] c, int len);
    logic [3:0] n;
    n = (c == 4'b1000 || c == 4'b1011 || c == 4'b1100 || c == 4'b1101 ||
         c == 4'b1001 || c == 4'b0010) ? c : 4'b0000;
    if (len > 1514 && !n[3]) n = 4'b1001;
    return n;
  endfunction

  function automatic logic [15:0] exp_status();
    return (mq.size() == 0) ? 16'h8000 : mq[0];
  endfunction

  task automatic check_state(string req);
    chk(req, status_word, exp_status());
    chk(req, status_ovr, mq.size() == 8);
    chk(req, rx_underrun, und);
    chk(req, adapter_fail, und);
  endtask

  task automatic send_pkt(int len, logic [3:0] code, bit mid);
    bit ok;
    int sat;
    ok = (mq.size() < 8);
    pkt_start = 1; @(negedge clk); pkt_start = 0;
    chk(ok ? "R9 start" : "R7 refused", receiving, ok);
    for (int i = 0; i < len; i++) begin
      byte_valid = 1; @(negedge clk);
      if (mid && ok && mq.size() == 0 && i == len / 2)
        chk("R3 running", status_word, {5'b10000, 11'(i + 1)});
    end
    byte_valid = 0; pkt_end = 1; err_code = code; @(negedge clk);
    pkt_end = 0; err_code = 0;
    sat = (len > 2047) ? 2047 : len;
    if (ok) mq.push_back({1'b0, exp_code(code, len), 11'(sat)});
    chk("R9 end", receiving, 1'b0);
    check_state("R2 R4 R5 R6 R7 after frame");
  endtask

  task automatic do_discard();
    discard = 1; @(negedge clk); discard = 0;
    if (mq.size() > 0) begin void'(mq.pop_front()); rdc = 0; end
    check_state("R8 discard");
  endtask

  task automatic do_read();
    int limit;
    limit = (mq.size() > 0) ? int'(mq[0][10:0]) : 0;
    host_rd = 1; @(negedge clk); host_rd = 0;
    if (rdc >= limit) und = 1; else rdc++;
    check_state("R10 read");
  endtask

  task automatic do_rx_reset();
    rx_reset = 1; @(negedge clk); rx_reset = 0;
    mq.delete(); rdc = 0; und = 0;
    check_state("R11 rx reset");
    chk("R11 receiving", receiving, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check_state("R1 reset");
    chk("R1 receiving", receiving, 1'b0);

    send_pkt(64, 4'b0000, 1);
    do_discard();
    do_discard();                       // R8: empty queue, no effect
    for (int c = 0; c < 16; c++) begin  // R4: every code value
      send_pkt(60, 4'(c), 0);
      do_discard();
    end
    send_pkt(1514, 4'b0000, 0); do_discard();   // R5 boundary
    send_pkt(1515, 4'b0010, 0); do_discard();   // R5 oversize wins over dribble
    send_pkt(1600, 4'b1101, 0); do_discard();   // R5 CRC kept
    send_pkt(2100, 4'b0000, 1); do_discard();   // R5 saturation
    for (int k = 0; k < 8; k++) send_pkt(k + 1, 4'b0000, 0);  // R6 R7 fill
    send_pkt(5, 4'b1100, 0);            // R7 ninth refused
    for (int k = 0; k < 8; k++) do_discard();   // R6 order
    send_pkt(10, 4'b0000, 0);
    for (int k = 0; k < 11; k++) do_read();     // R10 eleventh read underruns
    do_discard();
    send_pkt(3, 4'b0000, 0);            // R10 sticky through new frame
    do_rx_reset();                      // R11
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 40) send_pkt($urandom_range(0, 40), 4'($urandom_range(0, 15)), op < 5);
      else if (op < 70) do_discard();
      else if (op < 97) do_read();
      else do_rx_reset();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule